// File: doc/BRIEF.md
# SPI Serial EEPROM Command Sequencer

This block sits between a simple host request port and a serial EEPROM that has a status register. The host asks for one of three operations: read a byte, write a byte, or write the status register. The block then runs every SPI frame that the operation needs. It generates SCK from the system clock, drives MOSI and an active-low chip select, and samples MISO. When the operation ends it returns the read data and a one-cycle done pulse.

Each write needs extra frames, and the block adds them without host help. It first sends a one-byte write-enable frame, then the write frame itself. It then sends read-status frames until the device reports that its internal write has finished. A host-supplied limit caps the number of polls. If the device is still busy when the limit is reached, the block reports the operation as timed out. The host sees only a request, a busy level and a done pulse.

Top module: `ee_cmd_seq`

## Requirements
- R1: A read request (`req_kind` = 0) sends one frame under a single chip-select assertion. The frame is four bytes: 0x03, the address high byte, the address low byte, and 0xFF as a dummy byte. The byte received during the dummy byte appears on `rdata` when `done` pulses.
- R2: Every byte goes out most significant bit first in SPI mode 0:
  - SCK idles low and is low whenever chip select is high.
  - MOSI changes only while SCK is low.
  - MISO is sampled on the rising edge of SCK.
- R3: A byte-write request (`req_kind` = 1) first sends a one-byte frame holding 0x06. Chip select is then released, and the next frame sends 0x02, the address high byte, the address low byte and the data byte.
- R4: A status-write request (`req_kind` = 2) sends the 0x06 frame and then a two-byte frame: 0x01 followed by the data byte, with no address.
- R5: After the write frame of R3 or R4, the block sends read-status frames. Each one is 0x05 followed by 0xFF under its own chip-select assertion. Polling continues until bit 0 of the returned status byte is 0, and that operation ends with `timeout` low.
- R6: Polling is capped by `max_polls`, where a value of 0 counts as 1. If that many status frames have all returned bit 0 set, the block ends the operation with `timeout` high at the `done` pulse. `timeout` stays valid until the next request is accepted.
- R7: Chip select stays high for at least `CLK_DIV` system clocks between two consecutive frames.
- R8: A request is accepted only while `busy` is low. When it is accepted, `busy` is high from the next clock through the `done` cycle. A request made while `busy` is high has no effect.
- R9: `done` is high for exactly one clock per accepted request, and `busy` is low in the clock after it.
- R10: A request with `req_kind` = 3 is not accepted. `busy` stays low and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_kind | input | 2 | 0 read, 1 write byte, 2 write status, 3 unused |
| req_addr | input | 16 | Byte address for read and write |
| req_wdata | input | 8 | Data byte for a byte or status write |
| max_polls | input | POLL_W | Status-poll limit (0 behaves as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| timeout | output | 1 | Last write gave up polling |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_csn | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The checker module checks the electrical rules on every cycle:
- SCK is low while chip select is high, and MOSI holds while SCK is high.
- Chip select has its minimum high time between frames.
- A request is accepted only when the block is idle, and an unused request kind is refused.
- `done` is a single pulse inside `busy`, and `timeout` rises only with `done`.

Some properties can only be seen from the bench's behavioural EEPROM. These are the frame contents and their order, write-enable before each write, polling on the busy bit, the exact poll count before a timeout, and the data read back.

// File: rtl/ee_seq_pkg.sv
package ee_seq_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_WRSR  = 2'd2,
        KIND_NONE  = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        FR_WREN,
        FR_WRITE,
        FR_READ,
        FR_WRSR,
        FR_RDSR
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP,
        ST_DONE
    } state_e;

    typedef struct packed {
        req_kind_e   kind;
        logic [15:0] addr;
        logic [7:0]  data;
    } req_t;

    // index of the final byte of a frame
    function automatic logic [1:0] frame_last(input frame_e f);
        case (f)
            FR_WREN:  return 2'd0;
            FR_WRSR:  return 2'd1;
            FR_RDSR:  return 2'd1;
            default:  return 2'd3;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(input frame_e f,
                                              input logic [1:0] idx,
                                              input req_t r);
        logic [7:0] b;
        b = FILL_BYTE;
        case (f)
            FR_WREN: b = OP_WREN;
            FR_RDSR: b = (idx == 2'd0) ? OP_RDSR : FILL_BYTE;
            FR_WRSR: b = (idx == 2'd0) ? OP_WRSR : r.data;
            FR_READ, FR_WRITE: begin
                case (idx)
                    2'd0: b = (f == FR_READ) ? OP_READ : OP_WRITE;
                    2'd1: b = r.addr[15:8];
                    2'd2: b = r.addr[7:0];
                    default: b = (f == FR_READ) ? FILL_BYTE : r.data;
                endcase
            end
            default: b = FILL_BYTE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ee_bit_shifter.sv
module ee_bit_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
    localparam int HW   = (HALF < 2) ? 1 : $clog2(HALF);

    logic          active;
    logic [7:0]    shreg;
    logic [2:0]    bitn;
    logic [HW-1:0] hcnt;

    assign mosi = shreg[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            shreg     <= '0;
            bitn      <= '0;
            hcnt      <= '0;
            sck       <= 1'b0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                shreg  <= tx_byte;
                bitn   <= '0;
                hcnt   <= '0;
                sck    <= 1'b0;
            end else if (active) begin
                if (hcnt == HW'(HALF - 1)) begin
                    hcnt <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + HW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ee_poll_counter.sv
module ee_poll_counter #(
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    input  logic [POLL_W-1:0] limit,
    output logic              exhausted
);
    logic [POLL_W-1:0] count;
    logic [POLL_W-1:0] eff_limit;

    assign eff_limit = (limit == '0) ? POLL_W'(1) : limit;
    assign exhausted = (count >= eff_limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + POLL_W'(1);
        end
    end
endmodule

// File: rtl/ee_cmd_seq.sv
module ee_cmd_seq
    import ee_seq_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int POLL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [15:0]       req_addr,
    input  logic [7:0]        req_wdata,
    input  logic [POLL_W-1:0] max_polls,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rdata,
    output logic              timeout,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              spi_csn,
    input  logic              spi_miso
);
    localparam int GAP_CYC = (CLK_DIV < 2) ? 2 : CLK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    state_e        state;
    frame_e        frame;
    req_t          req_q;
    logic [1:0]    byte_idx;
    logic [GW-1:0] gap_cnt;
    logic [7:0]    last_status;
    logic          csn_q;

    logic          sh_start;
    logic          sh_done;
    logic [7:0]    sh_rx;
    logic [7:0]    sh_tx;
    logic          poll_clr;
    logic          poll_inc;
    logic          poll_out;
    logic          accept;
    logic          last_byte;

    assign accept    = (state == ST_IDLE) && req_valid && (req_kind != KIND_NONE);
    assign sh_start  = (state == ST_LOAD);
    assign sh_tx     = frame_byte(frame, byte_idx, req_q);
    assign last_byte = (byte_idx == frame_last(frame));
    assign poll_clr  = accept;
    assign poll_inc  = (state == ST_SHIFT) && sh_done && last_byte && (frame == FR_RDSR);

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign spi_csn = csn_q;

    ee_bit_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

    ee_poll_counter #(.POLL_W(POLL_W)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (poll_clr),
        .inc       (poll_inc),
        .limit     (max_polls),
        .exhausted (poll_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            frame       <= FR_READ;
            req_q       <= '0;
            byte_idx    <= '0;
            gap_cnt     <= '0;
            last_status <= '0;
            csn_q       <= 1'b1;
            rdata       <= '0;
            timeout     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        req_q    <= '{kind: req_kind_e'(req_kind), addr: req_addr, data: req_wdata};
                        frame    <= (req_kind == KIND_READ) ? FR_READ : FR_WREN;
                        byte_idx <= '0;
                        timeout  <= 1'b0;
                        csn_q    <= 1'b0;
                        state    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (last_byte) begin
                            csn_q   <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                            if (frame == FR_RDSR) last_status <= sh_rx;
                            if (frame == FR_READ) rdata <= sh_rx;
                        end else begin
                            byte_idx <= byte_idx + 2'd1;
                            state    <= ST_LOAD;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(GAP_CYC - 1)) begin
                        byte_idx <= '0;
                        case (frame)
                            FR_WREN: begin
                                frame <= (req_q.kind == KIND_WRITE) ? FR_WRITE : FR_WRSR;
                                csn_q <= 1'b0;
                                state <= ST_LOAD;
                            end
                            FR_WRITE, FR_WRSR: begin
                                frame <= FR_RDSR;
                                csn_q <= 1'b0;
                                state <= ST_LOAD;
                            end
                            FR_RDSR: begin
                                if (!last_status[0]) begin
                                    state <= ST_DONE;
                                end else if (poll_out) begin
                                    timeout <= 1'b1;
                                    state   <= ST_DONE;
                                end else begin
                                    csn_q <= 1'b0;
                                    state <= ST_LOAD;
                                end
                            end
                            default: state <= ST_DONE;
                        endcase
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ee_cmd_seq_chk.sv
module ee_cmd_seq_chk #(
    parameter int CLK_DIV = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic       spi_csn
);
    logic [15:0] hi_cnt;
    logic        seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else if (spi_csn) begin
            if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
        end else begin
            hi_cnt     <= '0;
            seen_frame <= 1'b1;
        end
    end

    a_r2_sck_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sck);

    a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r7_csn_gap: assert property (@(posedge clk) disable iff (rst)
        (seen_frame && $fell(spi_csn)) |-> (hi_cnt >= 16'(CLK_DIV)));

    a_r8_accept_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_kind != 2'd3) |=> busy);

    a_r8_done_inside_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r6_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> done);

    a_r10_unused_kind_refused: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_kind == 2'd3) |=> !busy);
endmodule

bind ee_cmd_seq ee_cmd_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_csn   (spi_csn)
);

// File: tb/ee_cmd_seq_tb.sv
module ee_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int POLL_W     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = 2'd0;
    logic [15:0]       req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic [POLL_W-1:0] max_polls = 8'd8;
    logic              busy, done, timeout;
    logic [7:0]        rdata;
    logic              spi_sck, spi_mosi, spi_csn;
    logic              spi_miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_cmd_seq #(.CLK_DIV(CLK_DIV), .POLL_W(POLL_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .max_polls(max_polls),
        .busy(busy), .done(done), .rdata(rdata), .timeout(timeout),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_csn(spi_csn),
        .spi_miso(spi_miso)
    );

    // ---------------- behavioural EEPROM ----------------
    logic [7:0] mem [0:255];
    logic [7:0] stat_reg = 8'h00;
    logic       wel = 1'b0;
    int         busy_left = 0;
    int         busy_cfg = 0;
    int         bitc = 0;
    int         nbytes = 0;
    logic [7:0] shin = '0;
    logic [7:0] shout = '0;
    logic [7:0] fb [0:3];
    int         nframes = 0;
    logic [7:0] f_op [0:15];
    int         f_len [0:15];
    logic [7:0] f_b [0:15][0:3];

    always @(negedge spi_csn) begin
        bitc = 0;
        nbytes = 0;
    end

    always @(posedge spi_sck) begin
        if (!spi_csn) begin
            shin = {shin[6:0], spi_mosi};
            bitc = bitc + 1;
            if (bitc == 8) begin
                if (nbytes < 4) fb[nbytes] = shin;
                nbytes = nbytes + 1;
                bitc = 0;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_csn) begin
            if (bitc == 0) begin
                shout = 8'h00;
                if (fb[0] == 8'h03 && nbytes == 3) shout = mem[fb[2]];
                if (fb[0] == 8'h05 && nbytes == 1) shout = {stat_reg[7:1], (busy_left != 0)};
            end else begin
                shout = {shout[6:0], 1'b0};
            end
            spi_miso = shout[7];
        end
    end

    always @(posedge spi_csn) begin
        if (nframes < 16) begin
            f_op[nframes]  = fb[0];
            f_len[nframes] = nbytes;
            for (int i = 0; i < 4; i++) f_b[nframes][i] = fb[i];
        end
        nframes = nframes + 1;
        if (fb[0] == 8'h06 && nbytes == 1) wel = 1'b1;
        if (fb[0] == 8'h02 && nbytes == 4 && wel) begin
            mem[fb[2]] = fb[3];
            wel = 1'b0;
            busy_left = busy_cfg;
        end
        if (fb[0] == 8'h01 && nbytes == 2 && wel) begin
            stat_reg = fb[1];
            wel = 1'b0;
            busy_left = busy_cfg;
        end
        if (fb[0] == 8'h05 && nbytes == 2 && busy_left > 0) busy_left = busy_left - 1;
    end

    // ---------------- protocol monitors ----------------
    int   hi_run = 0;
    int   min_gap = 1000;
    bit   any_frame = 0;
    bit   mosi_bad = 0;
    bit   sck_bad = 0;
    logic prev_sck = 0, prev_mosi = 0, prev_csn = 1;

    always @(posedge clk) begin
        if (!rst) begin
            if (spi_sck && prev_sck && spi_mosi != prev_mosi) mosi_bad = 1;
            if (spi_csn && spi_sck) sck_bad = 1;
            if (spi_csn) hi_run = hi_run + 1;
            if (!spi_csn && prev_csn) begin
                if (any_frame && hi_run < min_gap) min_gap = hi_run;
                any_frame = 1;
            end
            if (!spi_csn) hi_run = 0;
        end
        prev_sck = spi_sck;
        prev_mosi = spi_mosi;
        prev_csn = spi_csn;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] kind, input logic [15:0] addr,
                          input logic [7:0] data, input string req);
        int cyc;
        nframes = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8", {req, " busy after accept"}, busy, 1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R9", {req, " done seen"}, done, 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", {req, " done one cycle then idle"},
            {done, busy}, 0);
    endtask

    task automatic t_reset;
        chk(spi_csn == 1'b1, "R2", "reset csn high", spi_csn, 1);
        chk(spi_sck == 1'b0, "R2", "reset sck low", spi_sck, 0);
        chk(busy == 1'b0 && done == 1'b0, "R8", "reset idle", {busy, done}, 0);
    endtask

    task automatic t_read;
        mem[8'h34] = 8'hA5;
        run_op(2'd0, 16'h1234, 8'h00, "R1");
        chk(nframes == 1, "R1", "read frame count", nframes, 1);
        chk(f_len[0] == 4, "R1", "read frame length", f_len[0], 4);
        chk({f_b[0][0], f_b[0][1], f_b[0][2], f_b[0][3]} == 32'h031234FF, "R1",
            "read frame bytes", {f_b[0][0], f_b[0][1], f_b[0][2], f_b[0][3]}, 32'h031234FF);
        chk(rdata == 8'hA5, "R1", "read data", rdata, 8'hA5);
        mem[8'h35] = 8'h3C;
        run_op(2'd0, 16'h0035, 8'h00, "R1");
        chk(rdata == 8'h3C, "R1", "second read data", rdata, 8'h3C);
    endtask

    task automatic t_write;
        busy_cfg = 2; max_polls = 8'd8;
        run_op(2'd1, 16'h0042, 8'h96, "R3");
        chk(nframes == 5, "R5", "write frame count", nframes, 5);
        chk(f_op[0] == 8'h06 && f_len[0] == 1, "R3", "write enable first", f_op[0], 8'h06);
        chk({f_b[1][0], f_b[1][1], f_b[1][2], f_b[1][3]} == 32'h02004296, "R3",
            "write frame bytes", {f_b[1][0], f_b[1][1], f_b[1][2], f_b[1][3]}, 32'h02004296);
        chk(f_op[2] == 8'h05 && f_op[3] == 8'h05 && f_op[4] == 8'h05 && f_len[4] == 2
            && f_b[4][1] == 8'hFF, "R5", "status poll frames", f_op[4], 8'h05);
        chk(timeout == 1'b0, "R5", "no timeout", timeout, 0);
        chk(mem[8'h42] == 8'h96, "R3", "byte stored", mem[8'h42], 8'h96);
        run_op(2'd0, 16'h0042, 8'h00, "R1");
        chk(rdata == 8'h96, "R2", "msb-first readback", rdata, 8'h96);
    endtask

    task automatic t_wrsr;
        busy_cfg = 0; max_polls = 8'd8;
        run_op(2'd2, 16'hBEEF, 8'h8C, "R4");
        chk(nframes == 3, "R4", "status write frame count", nframes, 3);
        chk(f_op[0] == 8'h06 && f_op[1] == 8'h01 && f_len[1] == 2, "R4",
            "enable then two-byte status frame", f_len[1], 2);
        chk(stat_reg == 8'h8C, "R4", "status stored", stat_reg, 8'h8C);
        chk(f_op[2] == 8'h05 && timeout == 1'b0, "R5", "single poll", f_op[2], 8'h05);
    endtask

    task automatic t_timeout;
        busy_cfg = 5; max_polls = 8'd2;
        run_op(2'd1, 16'h0010, 8'h11, "R6");
        chk(nframes == 4, "R6", "frames before give-up", nframes, 4);
        chk(timeout == 1'b1, "R6", "timeout raised", timeout, 1);
        busy_left = 0;
        busy_cfg = 1; max_polls = 8'd0;
        run_op(2'd2, 16'h0000, 8'h00, "R6");
        chk(nframes == 3 && timeout == 1'b1, "R6", "zero limit acts as one", nframes, 3);
        busy_left = 0;
        busy_cfg = 0; max_polls = 8'd8;
        run_op(2'd0, 16'h0010, 8'h00, "R6");
        chk(timeout == 1'b0, "R6", "timeout cleared on next request", timeout, 0);
    endtask

    task automatic t_ignore_busy;
        int cyc;
        busy_cfg = 2; max_polls = 8'd8;
        nframes = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h0077; req_wdata = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_addr = 16'h0042;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        @(negedge clk);
        repeat (60) @(negedge clk);
        chk(nframes == 5, "R8", "request during busy ignored", nframes, 5);
        chk(busy == 1'b0 && mem[8'h77] == 8'h5A, "R8", "write unaffected", mem[8'h77], 8'h5A);
    endtask

    task automatic t_unused_kind;
        nframes = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd3;
        @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd0;
        chk(busy == 1'b0, "R10", "unused kind not accepted", busy, 0);
        repeat (40) @(negedge clk);
        chk(nframes == 0 && spi_csn == 1'b1, "R10", "no frame sent", nframes, 0);
    endtask

    task automatic t_monitors;
        chk(min_gap >= CLK_DIV, "R7", "min csn high gap", min_gap, CLK_DIV);
        chk(mosi_bad == 0, "R2", "mosi stable while sck high", mosi_bad, 0);
        chk(sck_bad == 0, "R2", "sck low while deselected", sck_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 4; i++) fb[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_wrsr();
        t_timeout();
        t_ignore_busy();
        t_unused_kind();
        t_monitors();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule